// File: doc/BRIEF.md
# Poolable Cache Way Steering Unit

This unit sits beside one layer's second-level cache in a vertically stacked multicore. Every way of the local cache carries a 2-bit ownership code: it serves the core on this layer, the core on the layer directly above, or the core on the layer directly below, or it is powered off. Lookups arrive on three requester ports (local, upper neighbour, lower neighbour). A requester only compares tags in the ways it owns. The hit flag and read data of each way go back to that owner alone. A requester whose returned hit is low sees a miss.

Software changes ownership by writing a new code for a way. If the way holds no dirty lines, the code takes effect at once. Otherwise the unit raises a busy flag. It walks the way's sets and offers each dirty line on a write-back port, holding it until that port acknowledges. It commits the new code only once the way is clean. Way 0 is kept for the local core and cannot be lent. An invalidate pulse clears all lines and returns every way to local ownership. The tag and data arrays are modelled behaviourally, with a fill port that loads lines.

Top module: `pool_way_steer`

## Requirements
- R1: After reset every way is owned locally (all `wayEnable` bits high), `busy`, `wbValid` and all `rspHit` bits are low.
- R2: Ownership codes are 00 = local, 01 = upper, 10 = lower, 11 = off. Requester port r (0 = local, 1 = upper, 2 = lower) hits only in a valid line of a way whose code equals r, in the set its index selects, with an equal tag.
- R3: A way with code 11 never produces a hit on any port and drives its `wayEnable` bit low.
- R4: On a miss the port's `rspHit` is 0 and its `rspData` is all zeros. On a hit `rspData` carries the hitting line's data.
- R5: A response appears in the cycle after the request (one register stage). A port with no request returns no hit.
- R6: Way 0 is reserved: a code write to it is ignored and its `wayEnable` bit stays high.
- R7: A code write to a way with no dirty lines commits on the same clock edge, and `busy` stays low.
- R8: A code write to a way with dirty lines raises `busy`. The old code stays in force while its dirty lines are offered on the write-back port in ascending set index. Each line's index, tag and data are held while `wbValid` is high until `wbAck`. The new code commits on the edge after the last line is acknowledged, when `busy` falls.
- R9: A code write presented while `busy` is high is ignored.
- R10: A fill aimed at the way being written back while `busy` is high is dropped.
- R11: An `invalidate` pulse clears every line, returns all ways to code 00, and aborts a write-back in progress (`busy` and `wbValid` low afterwards).
- R12: The three ports are served independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 3 | Lookup request per port (bit 0 local, 1 upper, 2 lower) |
| reqTag | input | 3*TAG_W | Lookup tag per port, port r at bits r*TAG_W |
| reqIdx | input | 3*IDX_W | Set index per port |
| rspHit | output | 3 | Registered hit per port |
| rspData | output | 3*DATA_W | Registered read data per port, zero on miss |
| fillValid | input | 1 | Load a line into the array |
| fillWay | input | WAY_W | Way to load |
| fillIdx | input | IDX_W | Set to load |
| fillTag | input | TAG_W | Tag of the loaded line |
| fillData | input | DATA_W | Data of the loaded line |
| fillDirty | input | 1 | Loaded line is dirty |
| cfgValid | input | 1 | Ownership code write strobe |
| cfgWay | input | WAY_W | Way whose code is written |
| cfgCode | input | 2 | New ownership code |
| invalidate | input | 1 | Clear all lines and ownership |
| busy | output | 1 | Write-back before reassignment in progress |
| wbValid | output | 1 | Dirty line offered for write-back |
| wbWay | output | WAY_W | Way being written back |
| wbIdx | output | IDX_W | Set of the offered line |
| wbTag | output | TAG_W | Tag of the offered line |
| wbData | output | DATA_W | Data of the offered line |
| wbAck | input | 1 | Write-back port accepts the offered line |
| wayEnable | output | NUM_WAYS | Power enable per way, low when the code is off |

## Verification
The bench goes after ownership isolation. A design that compared tags across all ways would let a neighbour hit in a way owned locally, or the reverse, with the tag present and only the code differing. The reassignment corner cases come next. A unit that committed early would stop serving the old owner during write-back, or would change ownership before the last acknowledgement. One that dropped `wbValid`, or moved its index before `wbAck`, would lose lines. Writes and fills arriving during write-back, a write to the reserved way, and an invalidate that aborts a write-back are each checked. A faulty unit would show a changed `wayEnable`, a stray hit, or a `busy` that never falls.

// File: rtl/pool_way_pkg.sv
package pool_way_pkg;
  // requester ports: 0 local, 1 upper layer, 2 lower layer
  localparam int NREQ = 3;

  typedef enum logic [1:0] {
    OWN_LOCAL = 2'b00,
    OWN_UP    = 2'b01,
    OWN_DOWN  = 2'b10,
    OWN_OFF   = 2'b11
  } ownCode_e;

  typedef struct packed {
    logic flushActive;
    logic clearDirty;
    logic invalidate;
  } ctrlStrobe_t;
endpackage

// File: rtl/pool_way_datapath.sv
module pool_way_datapath
  import pool_way_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [2*NUM_WAYS-1:0]   statusVec,
  input  logic [WAY_W-1:0]        flushWay,
  input  logic [IDX_W-1:0]        flushIdx,
  input  logic [NREQ-1:0]         reqValid,
  input  logic [NREQ*TAG_W-1:0]   reqTag,
  input  logic [NREQ*IDX_W-1:0]   reqIdx,
  input  logic                    fillValid,
  input  logic [WAY_W-1:0]        fillWay,
  input  logic [IDX_W-1:0]        fillIdx,
  input  logic [TAG_W-1:0]        fillTag,
  input  logic [DATA_W-1:0]       fillData,
  input  logic                    fillDirty,
  output logic [NREQ-1:0]         rspHit,
  output logic [NREQ*DATA_W-1:0]  rspData,
  output logic [NUM_WAYS-1:0]     wayDirty,
  output logic                    lineDirty,
  output logic [TAG_W-1:0]        wbTag,
  output logic [DATA_W-1:0]       wbData,
  output logic [NUM_WAYS-1:0]     wayEnable
);
  logic [TAG_W-1:0]    tagMem  [NUM_WAYS][NUM_SETS];
  logic [DATA_W-1:0]   dataMem [NUM_WAYS][NUM_SETS];
  logic [NUM_SETS-1:0] validBits [NUM_WAYS];
  logic [NUM_SETS-1:0] dirtyBits [NUM_WAYS];

  logic [TAG_W-1:0]  reqTagArr [NREQ];
  logic [IDX_W-1:0]  reqIdxArr [NREQ];
  logic [NREQ-1:0]   hitNext;
  logic [DATA_W-1:0] dataNext [NREQ];
  logic [DATA_W-1:0] dataQ    [NREQ];
  logic              fillTake;

  // the way under write-back takes no new lines
  assign fillTake = fillValid && !(strobe.flushActive && fillWay == flushWay);

  always_ff @(posedge clk) begin
    if (fillTake) begin
      tagMem[fillWay][fillIdx]  <= fillTag;
      dataMem[fillWay][fillIdx] <= fillData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        validBits[w] <= '0;
        dirtyBits[w] <= '0;
      end
    end else if (strobe.invalidate) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        validBits[w] <= '0;
        dirtyBits[w] <= '0;
      end
    end else begin
      if (strobe.clearDirty) dirtyBits[flushWay][flushIdx] <= 1'b0;
      if (fillTake) begin
        validBits[fillWay][fillIdx] <= 1'b1;
        dirtyBits[fillWay][fillIdx] <= fillDirty;
      end
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_req
    assign reqTagArr[r] = reqTag[r*TAG_W +: TAG_W];
    assign reqIdxArr[r] = reqIdx[r*IDX_W +: IDX_W];
    assign rspData[r*DATA_W +: DATA_W] = dataQ[r];
  end

  // ownership-gated compare: port r looks only at ways whose code is r
  always_comb begin
    for (int r = 0; r < NREQ; r++) begin
      hitNext[r]  = 1'b0;
      dataNext[r] = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (reqValid[r] && statusVec[2*w +: 2] == 2'(r) &&
            validBits[w][reqIdxArr[r]] &&
            tagMem[w][reqIdxArr[r]] == reqTagArr[r]) begin
          hitNext[r]  = 1'b1;
          dataNext[r] = dataNext[r] | dataMem[w][reqIdxArr[r]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit <= '0;
      for (int r = 0; r < NREQ; r++) dataQ[r] <= '0;
    end else if (strobe.invalidate) begin
      rspHit <= '0;
      for (int r = 0; r < NREQ; r++) dataQ[r] <= '0;
    end else begin
      rspHit <= hitNext;
      for (int r = 0; r < NREQ; r++) dataQ[r] <= dataNext[r];
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) wayDirty[w] = |dirtyBits[w];
  end

  assign lineDirty = dirtyBits[flushWay][flushIdx];
  assign wbTag     = tagMem[flushWay][flushIdx];
  assign wbData    = dataMem[flushWay][flushIdx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_pwr
    assign wayEnable[w] = (statusVec[2*w +: 2] != OWN_OFF);
  end
endmodule

// File: rtl/pool_way_control.sv
module pool_way_control
  import pool_way_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgValid,
  input  logic [WAY_W-1:0]      cfgWay,
  input  logic [1:0]            cfgCode,
  input  logic                  invalidate,
  input  logic                  wbAck,
  input  logic [NUM_WAYS-1:0]   wayDirty,
  input  logic                  lineDirty,
  output ctrlStrobe_t           strobe,
  output logic [2*NUM_WAYS-1:0] statusVec,
  output logic [WAY_W-1:0]      flushWay,
  output logic [IDX_W-1:0]      flushIdx,
  output logic                  busy,
  output logic                  wbValid
);
  typedef enum logic {ST_IDLE, ST_FLUSH} state_e;

  state_e           state;
  logic [1:0]       statusReg [NUM_WAYS];
  logic [WAY_W-1:0] pendWay;
  logic [1:0]       pendCode;
  logic [IDX_W-1:0] scanIdx;
  logic             cfgTake;

  // way 0 is the reserved local way
  assign cfgTake = (state == ST_IDLE) && cfgValid && (cfgWay != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendWay  <= '0;
      pendCode <= OWN_LOCAL;
      scanIdx  <= '0;
      for (int w = 0; w < NUM_WAYS; w++) statusReg[w] <= OWN_LOCAL;
    end else if (invalidate) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
      for (int w = 0; w < NUM_WAYS; w++) statusReg[w] <= OWN_LOCAL;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cfgTake) begin
            if (wayDirty[cfgWay]) begin
              pendWay  <= cfgWay;
              pendCode <= cfgCode;
              scanIdx  <= '0;
              state    <= ST_FLUSH;
            end else begin
              statusReg[cfgWay] <= cfgCode;
            end
          end
        end
        ST_FLUSH: begin
          if (!wayDirty[pendWay]) begin
            statusReg[pendWay] <= pendCode;
            state              <= ST_IDLE;
          end else if (!lineDirty || wbAck) begin
            scanIdx <= (scanIdx == IDX_W'(NUM_SETS - 1)) ? '0 : scanIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy               = (state == ST_FLUSH);
  assign wbValid            = busy && lineDirty;
  assign strobe.flushActive = busy;
  assign strobe.clearDirty  = wbValid && wbAck;
  assign strobe.invalidate  = invalidate;
  assign flushWay           = pendWay;
  assign flushIdx           = scanIdx;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_flat
    assign statusVec[2*w +: 2] = statusReg[w];
  end
endmodule

// File: rtl/pool_way_steer.sv
module pool_way_steer
  import pool_way_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [2:0]                        reqValid,
  input  logic [3*TAG_W-1:0]                reqTag,
  input  logic [3*$clog2(NUM_SETS)-1:0]     reqIdx,
  output logic [2:0]                        rspHit,
  output logic [3*DATA_W-1:0]               rspData,
  input  logic                              fillValid,
  input  logic [$clog2(NUM_WAYS)-1:0]       fillWay,
  input  logic [$clog2(NUM_SETS)-1:0]       fillIdx,
  input  logic [TAG_W-1:0]                  fillTag,
  input  logic [DATA_W-1:0]                 fillData,
  input  logic                              fillDirty,
  input  logic                              cfgValid,
  input  logic [$clog2(NUM_WAYS)-1:0]       cfgWay,
  input  logic [1:0]                        cfgCode,
  input  logic                              invalidate,
  output logic                              busy,
  output logic                              wbValid,
  output logic [$clog2(NUM_WAYS)-1:0]       wbWay,
  output logic [$clog2(NUM_SETS)-1:0]       wbIdx,
  output logic [TAG_W-1:0]                  wbTag,
  output logic [DATA_W-1:0]                 wbData,
  input  logic                              wbAck,
  output logic [NUM_WAYS-1:0]               wayEnable
);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);

  ctrlStrobe_t           strobe;
  logic [2*NUM_WAYS-1:0] statusVec;
  logic [NUM_WAYS-1:0]   wayDirty;
  logic                  lineDirty;
  logic [WAY_W-1:0]      flushWay;
  logic [IDX_W-1:0]      flushIdx;

  pool_way_control #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWay(cfgWay),
    .cfgCode(cfgCode), .invalidate(invalidate), .wbAck(wbAck),
    .wayDirty(wayDirty), .lineDirty(lineDirty), .strobe(strobe),
    .statusVec(statusVec), .flushWay(flushWay), .flushIdx(flushIdx),
    .busy(busy), .wbValid(wbValid)
  );

  pool_way_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
                      .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusVec(statusVec),
    .flushWay(flushWay), .flushIdx(flushIdx), .reqValid(reqValid),
    .reqTag(reqTag), .reqIdx(reqIdx), .fillValid(fillValid),
    .fillWay(fillWay), .fillIdx(fillIdx), .fillTag(fillTag),
    .fillData(fillData), .fillDirty(fillDirty), .rspHit(rspHit),
    .rspData(rspData), .wayDirty(wayDirty), .lineDirty(lineDirty),
    .wbTag(wbTag), .wbData(wbData), .wayEnable(wayEnable)
  );

  assign wbWay = flushWay;
  assign wbIdx = flushIdx;
endmodule

// File: rtl/pool_way_steer_chk.sv
module pool_way_steer_chk #(
  parameter int NUM_WAYS = 4,
  parameter int IDX_W    = 3,
  parameter int DATA_W   = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            reqValid,
  input logic [2:0]            rspHit,
  input logic [3*DATA_W-1:0]   rspData,
  input logic                  invalidate,
  input logic                  busy,
  input logic                  wbValid,
  input logic [IDX_W-1:0]      wbIdx,
  input logic [DATA_W-1:0]     wbData,
  input logic                  wbAck,
  input logic [NUM_WAYS-1:0]   wayEnable
);
  for (genvar r = 0; r < 3; r++) begin : g_port
    // R5
    hit_has_request_chk: assert property (@(posedge clk) disable iff (!rstN)
      rspHit[r] |-> $past(reqValid[r]));
    // R4
    miss_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !rspHit[r] |-> (rspData[r*DATA_W +: DATA_W] == '0));
  end

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN || invalidate)
    (wbValid && !wbAck) |=> (wbValid && $stable(wbIdx) && $stable(wbData)));

  // R8
  wb_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> busy);

  // R8
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(wayEnable)));

  // R6
  reserved_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    wayEnable[0]);
endmodule

bind pool_way_steer pool_way_steer_chk #(
  .NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspHit(rspHit),
  .rspData(rspData), .invalidate(invalidate), .busy(busy),
  .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .wbAck(wbAck),
  .wayEnable(wayEnable)
);

// File: tb/pool_way_steer_bench.sv
`timescale 1ns/1ps
module pool_way_steer_bench;
  localparam int TW = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int WW = 2;
  localparam logic [1:0] C_LOCAL = 2'b00, C_UP = 2'b01, C_DOWN = 2'b10, C_OFF = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]      reqValid = '0;
  logic [3*TW-1:0] reqTag = '0;
  logic [3*IW-1:0] reqIdx = '0;
  logic [2:0]      rspHit;
  logic [3*DW-1:0] rspData;
  logic            fillValid = 1'b0;
  logic [WW-1:0]   fillWay = '0;
  logic [IW-1:0]   fillIdx = '0;
  logic [TW-1:0]   fillTag = '0;
  logic [DW-1:0]   fillData = '0;
  logic            fillDirty = 1'b0;
  logic            cfgValid = 1'b0;
  logic [WW-1:0]   cfgWay = '0;
  logic [1:0]      cfgCode = '0;
  logic            invalidate = 1'b0;
  logic            busy, wbValid;
  logic [WW-1:0]   wbWay;
  logic [IW-1:0]   wbIdx;
  logic [TW-1:0]   wbTag;
  logic [DW-1:0]   wbData;
  logic            wbAck = 1'b0;
  logic [3:0]      wayEnable;

  pool_way_steer u_pool_way_steer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .reqIdx(reqIdx), .rspHit(rspHit), .rspData(rspData),
    .fillValid(fillValid), .fillWay(fillWay), .fillIdx(fillIdx),
    .fillTag(fillTag), .fillData(fillData), .fillDirty(fillDirty),
    .cfgValid(cfgValid), .cfgWay(cfgWay), .cfgCode(cfgCode),
    .invalidate(invalidate), .busy(busy), .wbValid(wbValid),
    .wbWay(wbWay), .wbIdx(wbIdx), .wbTag(wbTag), .wbData(wbData),
    .wbAck(wbAck), .wayEnable(wayEnable)
  );

  // port order inside each packed field: {lower, upper, local}
  typedef struct packed {
    logic [2:0]         v;
    logic [2:0][TW-1:0] tag;
    logic [2:0][IW-1:0] idx;
    logic [2:0]         eh;
    logic [2:0][DW-1:0] ed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'b001, {8'h00, 8'h00, 8'h11}, {3'd0, 3'd0, 3'd1}, 3'b001, {16'h0, 16'h0, 16'hA001}},
    '{3'b111, {8'h44, 8'h22, 8'h22}, {3'd3, 3'd1, 3'd1}, 3'b110, {16'hD004, 16'hB002, 16'h0}},
    '{3'b111, {8'h22, 8'h11, 8'h33}, {3'd1, 3'd1, 3'd2}, 3'b001, {16'h0, 16'h0, 16'hC003}},
    '{3'b111, {8'h34, 8'h33, 8'h44}, {3'd5, 3'd2, 3'd3}, 3'b000, {16'h0, 16'h0, 16'h0}},
    '{3'b000, {8'h44, 8'h22, 8'h11}, {3'd3, 3'd1, 3'd1}, 3'b000, {16'h0, 16'h0, 16'h0}},
    '{3'b111, {8'h44, 8'h23, 8'h11}, {3'd3, 3'd1, 3'd2}, 3'b100, {16'hD004, 16'h0, 16'h0}}
  };

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fillLine(input int w, input int i, input logic [TW-1:0] t, input logic [DW-1:0] d, input bit dirty);
    fillValid = 1'b1; fillWay = WW'(w); fillIdx = IW'(i);
    fillTag = t; fillData = d; fillDirty = dirty;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic writeCfg(input int w, input logic [1:0] c);
    cfgValid = 1'b1; cfgWay = WW'(w); cfgCode = c;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic expectLook(input int r, input logic [TW-1:0] t, input int i,
                            input bit eh, input logic [DW-1:0] ed, input string req);
    reqValid = '0;
    reqValid[r] = 1'b1;
    reqTag[r*TW +: TW] = t;
    reqIdx[r*IW +: IW] = IW'(i);
    @(negedge clk);
    reqValid = '0;
    check(rspHit[r] == eh && rspData[r*DW +: DW] == ed, req,
          {15'd0, rspHit[r], rspData[r*DW +: DW]}, {15'd0, eh, ed});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] heldIdx, seenIdx [4];
    logic [TW-1:0] seenTag [4];
    logic [DW-1:0] heldData, seenData [4];
    int hold, nWb, lastAck, endCyc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rspHit == 3'b000, "R1 no hit after reset", 32'(rspHit), 0);
    check(busy == 1'b0 && wbValid == 1'b0, "R1 idle after reset", {busy, wbValid}, 0);
    check(wayEnable == 4'hF, "R1 all ways local after reset", 32'(wayEnable), 32'hF);

    fillLine(0, 1, 8'h11, 16'hA001, 1'b0);
    fillLine(1, 1, 8'h22, 16'hB002, 1'b0);
    fillLine(2, 2, 8'h33, 16'hC003, 1'b1);
    fillLine(2, 5, 8'h34, 16'hC005, 1'b1);
    fillLine(3, 3, 8'h44, 16'hD004, 1'b0);

    // R7 clean ways commit at once
    writeCfg(1, C_UP);
    check(busy == 1'b0, "R7 clean way to upper, no busy", 32'(busy), 0);
    writeCfg(3, C_DOWN);
    check(busy == 1'b0, "R7 clean way to lower, no busy", 32'(busy), 0);

    // R2 R4 R5 R12 vector table
    for (int k = 0; k < NVEC; k++) begin
      reqValid = VECS[k].v;
      reqTag   = VECS[k].tag;
      reqIdx   = VECS[k].idx;
      @(negedge clk);
      reqValid = '0;
      for (int r = 0; r < 3; r++) begin
        check(rspHit[r] == VECS[k].eh[r] && rspData[r*DW +: DW] == VECS[k].ed[r],
              $sformatf("R2/R4/R5/R12 vector %0d port %0d", k, r),
              {15'd0, rspHit[r], rspData[r*DW +: DW]},
              {15'd0, VECS[k].eh[r], VECS[k].ed[r]});
      end
    end

    // R3 way turned off
    writeCfg(3, C_OFF);
    check(wayEnable == 4'b0111, "R3 off way loses enable", 32'(wayEnable), 32'h7);
    expectLook(2, 8'h44, 3, 1'b0, 16'h0, "R3 off way no hit for lower");
    expectLook(0, 8'h44, 3, 1'b0, 16'h0, "R3 off way no hit for local");

    // R6 reserved way
    writeCfg(0, C_OFF);
    check(wayEnable[0] == 1'b1, "R6 reserved way stays enabled", 32'(wayEnable), 32'h7);
    expectLook(0, 8'h11, 1, 1'b1, 16'hA001, "R6 reserved way still local");

    // R8 dirty reassignment with R9 and R10 injected during write-back
    writeCfg(2, C_DOWN);
    check(busy == 1'b1, "R8 busy after dirty reassignment", 32'(busy), 1);
    cfgValid = 1'b1; cfgWay = 2'd1; cfgCode = C_OFF;
    fillValid = 1'b1; fillWay = 2'd2; fillIdx = 3'd7;
    fillTag = 8'h55; fillData = 16'hE007; fillDirty = 1'b1;
    reqValid = 3'b001; reqTag[TW-1:0] = 8'h34; reqIdx[IW-1:0] = 3'd5;
    @(negedge clk);
    cfgValid = 1'b0; fillValid = 1'b0; reqValid = '0;
    check(rspHit[0] == 1'b1 && rspData[DW-1:0] == 16'hC005,
          "R8 old owner served during write-back", {rspHit[0], rspData[DW-1:0]}, {1'b1, 16'hC005});

    hold = 0; nWb = 0; lastAck = -100; endCyc = -1;
    heldIdx = '0; heldData = '0;
    for (int c = 0; c < 80; c++) begin
      wbAck = 1'b0;
      if (!busy) begin
        endCyc = c;
        break;
      end
      if (wbValid) begin
        if (hold == 0) begin
          heldIdx = wbIdx; heldData = wbData;
        end else begin
          check(wbIdx == heldIdx && wbData == heldData, "R8 line held until ack",
                {wbIdx, wbData}, {heldIdx, heldData});
        end
        if (hold == 2) begin
          if (nWb < 4) begin
            seenIdx[nWb] = wbIdx; seenTag[nWb] = wbTag; seenData[nWb] = wbData;
          end
          nWb++;
          wbAck = 1'b1;
          hold = 0;
          lastAck = c;
        end else begin
          hold++;
        end
      end
      @(negedge clk);
    end
    wbAck = 1'b0;

    check(nWb == 2, "R8 two dirty lines written back", nWb, 2);
    check(seenIdx[0] == 3'd2 && seenTag[0] == 8'h33 && seenData[0] == 16'hC003,
          "R8 first write-back line", {seenIdx[0], seenTag[0], seenData[0]}, {3'd2, 8'h33, 16'hC003});
    check(seenIdx[1] == 3'd5 && seenTag[1] == 8'h34 && seenData[1] == 16'hC005,
          "R8 second write-back line", {seenIdx[1], seenTag[1], seenData[1]}, {3'd5, 8'h34, 16'hC005});
    check(endCyc - lastAck == 2, "R8 commit on edge after last ack", endCyc - lastAck, 2);
    check(wayEnable == 4'b0111, "R9 write during busy ignored", 32'(wayEnable), 32'h7);
    expectLook(1, 8'h22, 1, 1'b1, 16'hB002, "R9 way 1 still owned by upper");
    expectLook(2, 8'h33, 2, 1'b1, 16'hC003, "R8 new owner hits after commit");
    expectLook(0, 8'h33, 2, 1'b0, 16'h0, "R8 old owner misses after commit");
    expectLook(2, 8'h55, 7, 1'b0, 16'h0, "R10 fill during write-back dropped");

    // R7 way now clean, returns to local at once
    writeCfg(2, C_LOCAL);
    check(busy == 1'b0, "R7 cleaned way reassigned without busy", 32'(busy), 0);
    expectLook(0, 8'h33, 2, 1'b1, 16'hC003, "R7 local owns way 2 again");

    // R11 invalidate aborts a write-back
    fillLine(1, 0, 8'h66, 16'hF000, 1'b1);
    writeCfg(1, C_OFF);
    check(busy == 1'b1, "R11 write-back started before invalidate", 32'(busy), 1);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    check(busy == 1'b0 && wbValid == 1'b0, "R11 write-back aborted", {busy, wbValid}, 0);
    check(wayEnable == 4'hF, "R11 all codes cleared to local", 32'(wayEnable), 32'hF);
    expectLook(0, 8'h11, 1, 1'b0, 16'h0, "R11 lines cleared way 0");
    expectLook(0, 8'h22, 1, 1'b0, 16'h0, "R11 lines cleared way 1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule